// File: doc/BRIEF.md
# I2S to Latched Dual-DAC Converter

This block accepts a standard I2S stream from a sample-rate converter acting as clock master: bit clock, word select and serial data. It re-shapes that stream for a stereo converter that has a separate serial data line and a separate load strobe for each channel, with one shared bit clock. For each channel, the 18 most significant bits of the incoming word go out MSB first on that channel's own data line. The channel's strobe is then pulsed, and the converter loads the word when the strobe falls. Left and right are therefore updated half a sample period apart.

The I2S inputs are sampled by a faster system clock. Bit-clock edges are found by comparing successive synchronised samples. The outgoing bit clock is the incoming one, delayed by the same pipeline as the data, so the two stay aligned. Data lines stay low except while a word is being shifted out. After reset, or after any word-select transition that does not land exactly on a 32-bit slot boundary, both strobes are held idle until two complete clean slots (one frame) have passed. A partially received word is therefore never loaded.

Top module: `i2s_to_dual_latch_dac`

## Requirements
- R1: From reset, both data lines and both strobes are low. No word is shifted or loaded until two consecutive slots of exactly 32 bit clocks, each opened by a word-select transition, have been seen. The first slot after reset has no opening transition.
- R2: The slot with word select low is left (`dac_data_o[0]`, `dac_latch_o[0]`) and the slot with word select high is right (index 1). The MSB is the bit sampled on the second rising bit clock after the word-select change. The 18 most significant bits appear MSB first, one per bit-clock period, on that channel's data line.
- R3: Data lines and strobes change only in the system-clock cycle in which `dac_bck_o` falls. `dac_bck_o` follows `i2s_bck_i` with a fixed delay.
- R4: A channel's strobe is high for exactly one bit-clock period. It rises on the `dac_bck_o` fall that follows the converter's rising-edge capture of the 18th bit, and the word loads when it falls.
- R5: The two strobes are never high together. In an unbroken stream, a right strobe falls exactly 32 bit clocks after the preceding left strobe falls.
- R6: Outside the 18-bit window of the channel being shifted, a data line is low. The data line is low while its strobe is high, and the other channel's line stays low throughout.
- R7: A word-select transition after a slot shorter than 32 bit clocks drops synchronisation. A word whose strobe has not yet risen is abandoned and never loaded. Loading resumes only after two more clean slots.
- R8: A slot that reaches 32 bit clocks without a word-select transition drops synchronisation in the same way as R7.
- R9: Bits below the 18 most significant of each slot are discarded and have no effect on the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the I2S inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_bck_i | input | 1 | I2S bit clock, 64 times the sample rate |
| i2s_ws_i | input | 1 | I2S word select: low = left, high = right |
| i2s_sd_i | input | 1 | I2S serial data, MSB first, one-bit delayed |
| dac_bck_o | output | 1 | Shared bit clock to the converter, delayed to match the data |
| dac_data_o | output | 2 | Per-channel serial data (bit 0 left, bit 1 right) |
| dac_latch_o | output | 2 | Per-channel load strobe; the word loads on its falling edge |

## Verification
The assertions take for granted the following about the inputs:
- Each bit-clock phase lasts at least two system-clock cycles, so that edge detection through the synchroniser sees every edge.
- Word select and serial data change only together with a falling bit clock.
- Word select alternates from slot to slot.

The stimulus keeps within these limits. It draws every phase length at random between four and six system clocks, and drives select and data in the same cycle as the bit-clock fall. It departs from legal framing only on purpose: a truncated slot, an overlong slot, and a slot cut short after its word was already complete. Each of these is followed by clean slots, so re-locking is observed.

// File: rtl/i2s_dual_dac_pkg.sv
package i2s_dual_dac_pkg;

    // Channel identity, equal to the I2S word-select level of its slot.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } dac_ch_e;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/i2s_in_sync.sv
module i2s_in_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bck_o,
    output logic rise_o,
    output logic fall_o,
    output logic ws_o,
    output logic sd_o
);

    localparam int unsigned CW = STAGES * 3;

    typedef struct packed {
        logic [CW-1:0] chain;
        logic          bck_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [2:0] synced;

    assign synced = st_q.chain[CW-1 -: 3];

    always_comb begin
        st_d          = st_q;
        st_d.chain    = {st_q.chain[CW-4:0], bck_i, ws_i, sd_i};
        st_d.bck_prev = synced[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bck_o  = st_q.bck_prev;
    assign rise_o = synced[2] & ~st_q.bck_prev;
    assign fall_o = ~synced[2] & st_q.bck_prev;
    assign ws_o   = synced[1];
    assign sd_o   = synced[0];

    // R3: a detected edge always moves the delayed bit clock in its direction
    p_edge_moves_bck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> bck_o);

endmodule

// File: rtl/i2s_slot_tracker.sv
module i2s_slot_tracker
    import i2s_dual_dac_pkg::*;
#(
    parameter int unsigned SLOT_BITS   = 32,
    parameter int unsigned CLEAN_SLOTS = 2,
    parameter int unsigned CNT_W       = $clog2(SLOT_BITS + 1),
    parameter int unsigned LOCK_W      = $clog2(CLEAN_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             ws_i,
    input  logic             sd_i,
    output logic [CNT_W-1:0] cnt_o,
    output dac_ch_e          ch_o,
    output logic             bit_o,
    output logic             active_o
);

    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SLOT_BITS - 1);
    localparam logic [CNT_W-1:0]  CNT_VOID  = CNT_W'(SLOT_BITS);
    localparam logic [LOCK_W-1:0] LOCK_FULL = LOCK_W'(CLEAN_SLOTS);

    typedef struct packed {
        logic              ws_last;
        logic [CNT_W-1:0]  cnt;
        logic [LOCK_W-1:0] lock;
        logic              active;
        dac_ch_e           ch;
        logic              bit_v;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.ws_last = ws_i;
            st_d.bit_v   = sd_i;
            if (ws_i != st_q.ws_last) begin
                // Slot boundary: clean only if the previous slot was complete.
                st_d.cnt = '0;
                st_d.ch  = dac_ch_e'(ws_i);
                if (st_q.cnt == CNT_LAST) begin
                    st_d.lock = (st_q.lock == LOCK_FULL) ? st_q.lock : st_q.lock + 1'b1;
                end else begin
                    st_d.lock = '0;
                end
                st_d.active = (st_d.lock == LOCK_FULL);
            end else if (st_q.cnt != CNT_VOID) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_LAST) begin
                    // Slot overran without a word-select change.
                    st_d.lock   = '0;
                    st_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cnt     <= CNT_VOID;
            st_q.ch      <= CH_LEFT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign ch_o     = st_q.ch;
    assign bit_o    = st_q.bit_v;
    assign active_o = st_q.active;

    // R1: shifting is enabled only once the full run of clean slots is seen
    p_active_needs_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.lock == LOCK_FULL));

    // R7: a boundary at the wrong count disables the new slot
    p_bad_edge_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && (ws_i != st_q.ws_last) && (st_q.cnt != CNT_LAST))
        |=> (!st_q.active && (st_q.lock == '0)));

    // R8: running past the slot length disables the block
    p_overrun_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && (ws_i == st_q.ws_last) && (st_q.cnt == CNT_LAST))
        |=> (!st_q.active && (st_q.lock == '0)));

endmodule

// File: rtl/dac_lane.sv
module dac_lane
    import i2s_dual_dac_pkg::*;
#(
    parameter int unsigned IDX       = 0,
    parameter int unsigned WORD_BITS = 18,
    parameter int unsigned CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             active_i,
    input  dac_ch_e          ch_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             bit_i,
    output logic             data_o,
    output logic             lat_o
);

    localparam dac_ch_e          MY_CH    = dac_ch_e'(IDX % 2);
    localparam logic [CNT_W-1:0] WIN_LO   = CNT_W'(1);
    localparam logic [CNT_W-1:0] WIN_HI   = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] LATCH_AT = CNT_W'(WORD_BITS + 1);

    typedef struct packed {
        logic data;
        logic lat;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     mine;
    logic     in_win;

    assign mine   = active_i && (ch_i == MY_CH);
    assign in_win = (cnt_i >= WIN_LO) && (cnt_i <= WIN_HI);

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            st_d.data = (mine && in_win) ? bit_i : 1'b0;
            st_d.lat  = mine && (cnt_i == LATCH_AT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign lat_o  = st_q.lat;

    // R3: outputs hold between bit-clock falls
    p_change_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(st_q));

    // R6: data idles low whenever the strobe is up
    p_quiet_while_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lat |-> !st_q.data);

endmodule

// File: rtl/i2s_to_dual_latch_dac.sv
module i2s_to_dual_latch_dac
    import i2s_dual_dac_pkg::*;
#(
    parameter int unsigned WORD_BITS   = 18,
    parameter int unsigned SLOT_BITS   = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLEAN_SLOTS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i2s_bck_i,
    input  logic       i2s_ws_i,
    input  logic       i2s_sd_i,
    output logic       dac_bck_o,
    output logic [1:0] dac_data_o,
    output logic [1:0] dac_latch_o
);

    localparam int unsigned CNT_W  = $clog2(SLOT_BITS + 1);
    localparam int unsigned LOCK_W = $clog2(CLEAN_SLOTS + 1);

    logic             s_rise, s_fall, s_ws, s_sd;
    logic [CNT_W-1:0] t_cnt;
    dac_ch_e          t_ch;
    logic             t_bit, t_active;

    i2s_in_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .bck_i  (i2s_bck_i),
        .ws_i   (i2s_ws_i),
        .sd_i   (i2s_sd_i),
        .bck_o  (dac_bck_o),
        .rise_o (s_rise),
        .fall_o (s_fall),
        .ws_o   (s_ws),
        .sd_o   (s_sd)
    );

    i2s_slot_tracker #(
        .SLOT_BITS   (SLOT_BITS),
        .CLEAN_SLOTS (CLEAN_SLOTS),
        .CNT_W       (CNT_W),
        .LOCK_W      (LOCK_W)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (s_rise),
        .ws_i     (s_ws),
        .sd_i     (s_sd),
        .cnt_o    (t_cnt),
        .ch_o     (t_ch),
        .bit_o    (t_bit),
        .active_o (t_active)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        dac_lane #(
            .IDX       (g),
            .WORD_BITS (WORD_BITS),
            .CNT_W     (CNT_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .fall_i   (s_fall),
            .active_i (t_active),
            .ch_i     (t_ch),
            .cnt_i    (t_cnt),
            .bit_i    (t_bit),
            .data_o   (dac_data_o[g]),
            .lat_o    (dac_latch_o[g])
        );
    end

    // R5: the two channels never load at the same moment
    p_latch_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dac_latch_o));

    // R6: only one data line may be driving a word at any time
    p_single_lane_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dac_data_o));

endmodule

// File: tb/i2s_to_dual_latch_dac_bench.sv
module i2s_to_dual_latch_dac_bench;

    localparam int W    = 18;
    localparam int SLOT = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic       dbck;
    logic [1:0] ddata, dlat;

    always #10 clk = ~clk;

    i2s_to_dual_latch_dac u_i2s_to_dual_latch_dac (
        .clk         (clk),
        .rst_n       (rst_n),
        .i2s_bck_i   (bck),
        .i2s_ws_i    (ws),
        .i2s_sd_i    (sd),
        .dac_bck_o   (dbck),
        .dac_data_o  (ddata),
        .dac_latch_o (dlat)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver state seen by the monitor
    int          cur_k = -1;
    bit          cur_active = 1'b0;
    bit          cur_ch = 1'b0;
    logic [31:0] cur_word = '0;
    string       cur_req = "R6";

    // Bench model of synchronisation
    int          m_lock = 0;
    int          prev_len = 0;
    bit          prev_edge = 1'b0;
    bit          prev_loaded = 1'b0;
    logic [31:0] prev_word = '0;
    bit          next_ws = 1'b0;

    logic [17:0] expq0[$], expq1[$];
    bit          gapq0[$], gapq1[$];

    function automatic logic [17:0] top_bits(input logic [31:0] w);
        return w[31:14];
    endfunction

    // Monitor
    logic        dbck_p = 1'b0;
    logic [1:0]  dlat_p = '0, ddata_p = '0;
    logic [31:0] sh0 = '0, sh1 = '0;
    int          rc = 0, last_fall_rc = 0;

    task automatic latch_fall(input int c);
        logic [17:0] e, a;
        bit gap;
        a = (c == 0) ? sh0[18:1] : sh1[18:1];
        if ((c == 0 && expq0.size() == 0) || (c == 1 && expq1.size() == 0)) begin
            check(1'b0, "R7", 32'(a), 32'h0, "unexpected load");
        end else begin
            if (c == 0) begin e = expq0.pop_front(); gap = gapq0.pop_front(); end
            else        begin e = expq1.pop_front(); gap = gapq1.pop_front(); end
            check(a == e, "R2", 32'(a), 32'(e), "loaded word (R9 truncation)");
            if (gap) check(rc - last_fall_rc == SLOT, "R5", 32'(rc - last_fall_rc),
                           32'(SLOT), "strobe spacing");
        end
        check(ddata == 2'b00, "R6", 32'(ddata), 32'h0, "data idle at load");
        last_fall_rc = rc;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ddata != ddata_p) begin
                check(dbck_p && !dbck, "R3", 32'(dbck), 32'h0, "data moved off a bck fall");
            end
            if (dbck && !dbck_p) begin
                rc++;
                sh0 = {sh0[30:0], ddata[0]};
                sh1 = {sh1[30:0], ddata[1]};
                if (cur_k >= 1) begin
                    for (int c = 0; c < 2; c++) begin
                        bit inwin, exp_d, exp_l;
                        inwin = cur_active && (cur_ch == c[0]) && cur_k >= 2 && cur_k <= W + 1;
                        exp_d = inwin ? cur_word[SLOT + 1 - cur_k] : 1'b0;
                        exp_l = cur_active && (cur_ch == c[0]) && cur_k == W + 2;
                        check(ddata[c] == exp_d, inwin ? "R2" : cur_req, 32'(ddata[c]),
                              32'(exp_d), "data bit");
                        check(dlat[c] == exp_l, "R4", 32'(dlat[c]), 32'(exp_l), "strobe level");
                    end
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (dlat_p[c] && !dlat[c]) latch_fall(c);
            end
        end
        dbck_p  = dbck;
        dlat_p  = dlat;
        ddata_p = ddata;
    end

    task automatic send_period(input int k, input bit w, input bit d);
        int hp;
        hp = 4 + int'($urandom_range(2));
        @(negedge clk);
        bck   = 1'b0;
        ws    = w;
        sd    = d;
        cur_k = k;
        repeat (hp) @(negedge clk);
        bck = 1'b1;
        repeat (hp) @(negedge clk);
    endtask

    task automatic send_slot(input logic [31:0] word, input int len, input bit first);
        bit w, good, act;
        w = next_ws;
        if (!first) begin
            good   = prev_edge && (prev_len == SLOT);
            m_lock = good ? ((m_lock < 2) ? m_lock + 1 : 2) : 0;
        end
        act = !first && (m_lock == 2);
        if (act && len >= W + 2) begin
            if (w == 1'b0) begin expq0.push_back(top_bits(word)); gapq0.push_back(prev_loaded && prev_len == SLOT); end
            else           begin expq1.push_back(top_bits(word)); gapq1.push_back(prev_loaded && prev_len == SLOT); end
        end
        cur_active = act;
        cur_ch     = w;
        cur_word   = word;
        for (int k = 0; k < len; k++) begin
            bit d;
            if (k == 0)         d = prev_word[0];
            else if (k < SLOT)  d = word[SLOT - k];
            else                d = 1'($urandom);
            send_period(k, w, d);
        end
        prev_loaded = act && len >= W + 2;
        prev_word   = word;
        prev_len    = len;
        prev_edge   = !first;
        next_ws     = ~w;
    endtask

    task automatic run_clean(input int n);
        for (int i = 0; i < n; i++) send_slot($urandom, SLOT, 1'b0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7719));
        repeat (5) @(negedge clk);
        // R1: reset state
        check(ddata == 2'b00, "R1", 32'(ddata), 32'h0, "data in reset");
        check(dlat == 2'b00, "R1", 32'(dlat), 32'h0, "strobes in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        cur_req = "R1";
        send_slot($urandom, SLOT, 1'b1);
        run_clean(3);
        cur_req = "R6";
        run_clean(16);

        // R7: slot cut short before its word completes
        cur_req = "R7";
        send_slot(32'hA5A5_A5A5, 10, 1'b0);
        run_clean(3);
        cur_req = "R6";
        run_clean(6);

        // R7: slot cut short after its strobe already fired
        cur_req = "R7";
        send_slot($urandom, 25, 1'b0);
        run_clean(3);
        cur_req = "R6";
        run_clean(6);

        // R8: slot overruns its length
        cur_req = "R8";
        send_slot($urandom, 40, 1'b0);
        run_clean(3);
        cur_req = "R6";

        // R9 and corner words
        send_slot(32'hFFFF_FFFF, SLOT, 1'b0);
        send_slot(32'h0000_0000, SLOT, 1'b0);
        send_slot(32'h0000_3FFF, SLOT, 1'b0);
        send_slot(32'hFFFF_C000, SLOT, 1'b0);
        send_slot(32'h8000_0000, SLOT, 1'b0);
        send_slot(32'h0000_4000, SLOT, 1'b0);
        run_clean(8);

        send_slot($urandom, 5, 1'b0);
        repeat (20) @(negedge clk);
        // R7: every expected load happened, none left pending
        check(expq0.size() == 0, "R7", 32'(expq0.size()), 32'h0, "left loads pending");
        check(expq1.size() == 0, "R7", 32'(expq1.size()), 32'h0, "right loads pending");
        summary();
        $finish;
    end

endmodule